// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block generates the active-low system reset for a serial memory supervisor. Reset has two sources. The first is a supply-good level that arrives already synchronized, which covers power-up and brownout. The second is a watchdog that the host keeps alive by pulling the chip-select line low. Once the supply is good, reset is held for a fixed number of ticks before it is released. If the watchdog expires, it produces a reset pulse of fixed length and then starts counting again from zero. While reset is asserted, a serial-bus inhibit flag stays high so that the command logic drops and refuses any transfer.

All periods are counted in units of a one-cycle `tick` input. A tick of 1 ms gives the default parameters, which are 200 ms hold, 200 ms pulse and watchdog periods of 1.4 s, 600 ms and 200 ms. Simulation can use much shorter counts. The 2-bit timeout code comes from the status register. The controller copies it into an active copy only when the command logic reports a completed read or write command, or while the supply is down. The block has no data stream, so all pins are plain control and status signals.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `supply_ok` is 0, `rst_out_n` is 0 and `bus_inhibit` is 1 in the same cycle, with no clock edge needed. After `rst_n` the block is in the supply-hold phase with reset asserted.
- R2: Reset releases on the clock edge that consumes the HOLD_TICKS-th tick seen while `supply_ok` has stayed 1. If `supply_ok` drops before that, the hold count restarts from zero.
- R3: `bus_inhibit` is always the inverse of `rst_out_n`.
- R4: The active code selects the watchdog period, counted in ticks: 2'b00 gives WD_LONG_TICKS, 2'b01 gives WD_MID_TICKS, 2'b10 gives WD_SHORT_TICKS, and 2'b11 disables the watchdog. The code after `rst_n` is 2'b11. When the count reaches the period, reset asserts on the edge that consumes the last tick.
- R5: A high-to-low transition of `cs_n`, passed through a two-flop synchronizer, clears the watchdog count. A low-to-high transition does not clear it. If the restart and the expiring tick fall in the same cycle, the restart wins.
- R6: A watchdog reset lasts exactly PULSE_TICKS ticks. After it ends, the watchdog counts again from zero under the same code.
- R7: `wd_code` is copied into the active code only in a cycle where `cmd_done` is 1 or `supply_ok` is 0. A change of `wd_code` at any other time has no effect on the period.
- R8: If the supply drops during a watchdog pulse, the block goes to the supply-hold phase, waits the full HOLD_TICKS after the supply returns, and then starts the watchdog from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| tick | input | 1 | One-cycle time-base pulse |
| supply_ok | input | 1 | Synchronized supply-above-threshold level |
| cs_n | input | 1 | Chip select / watchdog restart pin, asynchronous |
| wd_code | input | 2 | Timeout code from the status register |
| cmd_done | input | 1 | Pulse: a read or write command completed |
| rst_out_n | output | 1 | Active-low system reset |
| bus_inhibit | output | 1 | High while serial traffic must be blocked |

## Verification
The bench targets the following corner cases:

- **Supply glitch during the hold interval.** A design that does not restart the hold count would release early.
- **Restart edge on the same cycle as the expiring tick.** A design that gives priority to the timeout would fire a spurious reset.
- **Rising edge of chip select.** A design that restarts on both edges would hide a host that is stuck with chip select low.
- **Timeout code written without a command completing.** A design that applies the code at once would change the period in the middle of an interval.
- **Supply loss during a watchdog pulse.** A design that keeps the pulse count would release after the rest of the pulse instead of after a full hold.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_RUN   = 2'd1,
    PH_WDRST = 2'd2
  } sup_phase_e;

  localparam logic [1:0] WD_CODE_OFF = 2'b11;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_cs_sync.sv
module sup_cs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  output logic cs_fall
);
  logic [2:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 3'b111;
    else        stage_q <= {stage_q[1:0], cs_n_pin};
  end

  assign cs_fall = stage_q[2] & ~stage_q[1];

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !cs_fall); // R5

endmodule

// File: rtl/sup_tick_count.sv
module sup_tick_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          done
);
  logic [CW-1:0] last;

  assign last = limit - 1'b1;
  assign done = en && tick && !clr && (count >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clr)            count <= '0;
    else if (en && tick) begin
      if (done) count <= '0;
      else      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sup_wd_select.sv
module sup_wd_select #(
  parameter int CW          = 11,
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wd_code,
  input  logic          load,
  output logic [CW-1:0] limit,
  output logic          wd_en
);
  import sup_pkg::*;

  logic [1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= WD_CODE_OFF;
    else if (load) code_q <= wd_code;
  end

  always_comb begin
    case (code_q)
      2'b00:   limit = CW'(LONG_TICKS);
      2'b01:   limit = CW'(MID_TICKS);
      2'b10:   limit = CW'(SHORT_TICKS);
      default: limit = CW'(LONG_TICKS);
    endcase
    wd_en = (code_q != WD_CODE_OFF);
  end

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code_q)); // R7

endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
  parameter int HOLD_TICKS     = 200,
  parameter int PULSE_TICKS    = 200,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       cs_n,
  input  logic [1:0] wd_code,
  input  logic       cmd_done,
  output logic       rst_out_n,
  output logic       bus_inhibit
);
  import sup_pkg::*;

  localparam int MAX_T = imax(imax(HOLD_TICKS, PULSE_TICKS),
                              imax(WD_LONG_TICKS, imax(WD_MID_TICKS, WD_SHORT_TICKS)));
  localparam int CW = $clog2(MAX_T + 1);

  sup_phase_e    phase_q, phase_d;
  logic          cs_fall;
  logic [CW-1:0] hold_limit, hold_cnt, wd_limit, wd_cnt;
  logic          hold_done, wd_done, wd_en;
  logic          hold_en, hold_clr, wd_cnt_en, wd_clr;

  sup_cs_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_pin (cs_n),
    .cs_fall  (cs_fall)
  );

  sup_wd_select #(
    .CW          (CW),
    .LONG_TICKS  (WD_LONG_TICKS),
    .MID_TICKS   (WD_MID_TICKS),
    .SHORT_TICKS (WD_SHORT_TICKS)
  ) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_code (wd_code),
    .load    (cmd_done || !supply_ok),
    .limit   (wd_limit),
    .wd_en   (wd_en)
  );

  // Shared counter: supply hold time or watchdog pulse length
  assign hold_limit = (phase_q == PH_WDRST) ? CW'(PULSE_TICKS) : CW'(HOLD_TICKS);
  assign hold_en    = (phase_q != PH_RUN);
  assign hold_clr   = !supply_ok || (phase_q == PH_RUN);

  sup_tick_count #(.CW(CW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (hold_en),
    .clr   (hold_clr),
    .tick  (tick),
    .limit (hold_limit),
    .count (hold_cnt),
    .done  (hold_done)
  );

  // Watchdog interval counter; a restart edge beats an expiring tick
  assign wd_cnt_en = (phase_q == PH_RUN) && wd_en;
  assign wd_clr    = (phase_q != PH_RUN) || !supply_ok || cs_fall;

  sup_tick_count #(.CW(CW)) u_wd (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (wd_cnt_en),
    .clr   (wd_clr),
    .tick  (tick),
    .limit (wd_limit),
    .count (wd_cnt),
    .done  (wd_done)
  );

  always_comb begin
    phase_d = phase_q;
    if (!supply_ok) phase_d = PH_HOLD;
    else begin
      case (phase_q)
        PH_HOLD:  if (hold_done) phase_d = PH_RUN;
        PH_WDRST: if (hold_done) phase_d = PH_RUN;
        PH_RUN:   if (wd_done)   phase_d = PH_WDRST;
        default:                 phase_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_HOLD;
    else        phase_q <= phase_d;
  end

  assign rst_out_n   = supply_ok && (phase_q == PH_RUN);
  assign bus_inhibit = ~rst_out_n;

  AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!rst_out_n && bus_inhibit)); // R1

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick)); // R2

  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RUN) |-> (hold_cnt < hold_limit)); // R6

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && supply_ok && phase_q == PH_RUN) |=> (wd_cnt == '0 && rst_out_n)); // R5

  AST_INHIBIT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> bus_inhibit); // R3

endmodule

// File: tb/sup_reset_wdog_tb_top.sv
module sup_reset_wdog_tb_top;

  localparam int HOLD  = 5;
  localparam int PULSE = 6;
  localparam int LONG  = 40;
  localparam int MID   = 20;
  localparam int SHORT = 10;

  // {code[1:0], period[7:0]}; period 0 means watchdog disabled
  localparam logic [9:0] VEC [4] = '{
    {2'b10, 8'd10}, {2'b01, 8'd20}, {2'b00, 8'd40}, {2'b11, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n, tick, supply_ok, cs_n, cmd_done;
  logic [1:0] wd_code;
  logic rst_out_n, bus_inhibit;
  int ntot = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  sup_reset_wdog #(
    .HOLD_TICKS(HOLD), .PULSE_TICKS(PULSE),
    .WD_LONG_TICKS(LONG), .WD_MID_TICKS(MID), .WD_SHORT_TICKS(SHORT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .cs_n(cs_n), .wd_code(wd_code), .cmd_done(cmd_done),
    .rst_out_n(rst_out_n), .bus_inhibit(bus_inhibit)
  );

  task automatic chk(input string req, input logic exp_rst_n);
    ntot++;
    if (rst_out_n !== exp_rst_n || bus_inhibit !== ~exp_rst_n) begin
      nbad++;
      $display("FAIL %s: rst_out_n=%b bus_inhibit=%b expected rst_out_n=%b bus_inhibit=%b",
               req, rst_out_n, bus_inhibit, exp_rst_n, ~exp_rst_n);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic restart();
    cs_n = 1'b0; repeat (4) @(negedge clk);
    cs_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic apply_code(input logic [1:0] c);
    wd_code = c; cmd_done = 1'b1; @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic run_all();
    // reset state, R1
    rst_n = 1'b0; supply_ok = 1'b0; cs_n = 1'b1; tick = 1'b0;
    wd_code = 2'b11; cmd_done = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 1'b0);
    rst_n = 1'b1; @(negedge clk);
    ticks(10);
    chk("R1 supply low", 1'b0);

    // hold time with a glitch, R2
    supply_ok = 1'b1;
    ticks(HOLD - 1);
    chk("R2 before hold end", 1'b0);
    supply_ok = 1'b0; #1;
    chk("R1 immediate on glitch", 1'b0);
    @(negedge clk); supply_ok = 1'b1; @(negedge clk);
    ticks(HOLD - 1);
    chk("R2 hold restarted", 1'b0);
    ticks(1);
    chk("R2 release R3", 1'b1);

    // default code disables watchdog, R4
    ticks(60);
    chk("R4 default disabled", 1'b1);

    // table of codes, R4 and R6
    foreach (VEC[k]) begin
      apply_code(VEC[k][9:8]);
      restart();
      if (VEC[k][7:0] == 8'd0) begin
        ticks(60);
        chk("R4 code off", 1'b1);
      end else begin
        ticks(int'(VEC[k][7:0]) - 1);
        chk("R4 before timeout", 1'b1);
        ticks(1);
        chk("R4 timeout", 1'b0);
        ticks(PULSE - 1);
        chk("R6 pulse held", 1'b0);
        ticks(1);
        chk("R6 pulse end", 1'b1);
      end
    end

    // re-arm after pulse, R6
    apply_code(2'b10);
    restart();
    ticks(SHORT); ticks(PULSE);
    chk("R6 released", 1'b1);
    ticks(SHORT - 1);
    chk("R6 rearm from zero", 1'b1);
    ticks(1);
    chk("R6 second timeout", 1'b0);
    ticks(PULSE);

    // code change without command, R7
    wd_code = 2'b00;
    restart();
    ticks(SHORT);
    chk("R7 code not applied", 1'b0);
    ticks(PULSE);
    apply_code(2'b00);
    restart();
    ticks(LONG - 1);
    chk("R7 code applied on cmd_done", 1'b1);

    // restarts, R5
    restart();
    ticks(LONG - 1);
    chk("R5 falling edge restarts", 1'b1);
    ticks(1);
    chk("R5 expiry", 1'b0);
    ticks(PULSE);
    cs_n = 1'b0; repeat (4) @(negedge clk);
    ticks(20);
    cs_n = 1'b1; repeat (4) @(negedge clk);
    ticks(LONG - 21);
    chk("R5 before expiry after rise", 1'b1);
    ticks(1);
    chk("R5 rising edge ignored", 1'b0);
    ticks(PULSE);
    ticks(LONG - 1);
    cs_n = 1'b0; @(negedge clk); @(negedge clk);
    tick = 1'b1; @(negedge clk);
    tick = 1'b0;
    cs_n = 1'b1; repeat (4) @(negedge clk);
    chk("R5 edge beats tick", 1'b1);
    ticks(LONG - 1);
    chk("R5 count cleared", 1'b1);
    ticks(1);
    chk("R5 expiry after tie", 1'b0);

    // supply loss during pulse, R8 and power-cycle load, R7
    ticks(2);
    wd_code = 2'b01;
    supply_ok = 1'b0; @(negedge clk); @(negedge clk);
    chk("R1 loss in pulse", 1'b0);
    supply_ok = 1'b1;
    ticks(HOLD - 1);
    chk("R8 full hold", 1'b0);
    ticks(1);
    chk("R8 release", 1'b1);
    ticks(MID - 1);
    chk("R8 wd from zero R7 power load", 1'b1);
    ticks(1);
    chk("R7 mid period", 1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        ntot++; nbad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

endmodule